// File: doc/BRIEF.md
# Sequential Register-Pair Multiplier

This block carries out the one-byte unsigned multiply instruction of a small accumulator/index-register processor. When the instruction sequencer presents the multiply opcode on a start strobe, the block latches the current accumulator (A), index register (X) and condition-code register, then forms the 16-bit product X times A with a shift-and-add datapath that retires one multiplier bit per clock.

The product overwrites both source registers as a pair: the upper byte goes back to X and the lower byte to A. In the condition codes, the half-carry and carry flags are forced to zero and every other bit is passed through unchanged. The block takes a fixed 11 cycles from the start cycle to the done pulse. Its eight arithmetic steps are padded with idle cycles so that the sequencer never has to wait on a variable answer.

Top module: `regpair_mul`

## Requirements
- R1: An operation starts only when `startValid` is high, `startOpcode` equals 0x42 and `busy` is low. A strobe carrying any other opcode value leaves `busy` low and changes no output.
- R2: On completion, {`idxOut`,`accOut`} equals the unsigned 16-bit product of the `idxIn` and `accIn` values sampled in the start cycle.
- R3: The upper eight product bits appear on `idxOut` and the lower eight bits on `accOut`. For example, 0xFF times 0x02 gives `idxOut`=0x01 and `accOut`=0xFE.
- R4: On completion, the half-carry flag (`ccrOut` bit 4) and the carry flag (`ccrOut` bit 0) are zero.
- R5: On completion, every other `ccrOut` bit (interrupt mask bit 3, negative bit 2, zero bit 1, and bits 7:5) equals the matching `ccrIn` bit sampled in the start cycle.
- R6: If the start is sampled in cycle n, `busy` is high in cycles n+1 to n+10, and `done` is high for exactly one cycle, cycle n+11, with `busy` low. `busy` and `done` are never high together.
- R7: `accOut`, `idxOut` and `ccrOut` keep their previous values in every cycle except the cycle in which `done` is high, when all three change together.
- R8: A start strobe that arrives while `busy` is high is ignored. The running operation completes with its original operands and timing.
- R9: After reset, `busy`, `done`, `accOut`, `idxOut` and `ccrOut` are all zero.
- R10: The corner products are exact: 0xFF times 0xFF gives 0xFE01, any operand times zero gives 0x0000, and any operand times one gives that operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startValid | input | 1 | Start strobe from the sequencer |
| startOpcode | input | 8 | Opcode presented with the strobe |
| accIn | input | 8 | Accumulator value (multiplier) |
| idxIn | input | 8 | Index register value (multiplicand) |
| ccrIn | input | 8 | Incoming condition-code register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| accOut | output | 8 | New accumulator (product low byte) |
| idxOut | output | 8 | New index register (product high byte) |
| ccrOut | output | 8 | Updated condition-code register |

## Verification
Directed operand pairs cover the extremes: 0xFF by 0xFF exercises a carry into every partial-sum bit, zero and one on either side separate the multiplicand and multiplier roles, and 0xFF by 0x02 shows whether the two bytes are swapped. Random operand pairs and random incoming flag bytes then compare each product and flag byte against a reference multiply, and catch shift or add errors that hit only some bit patterns. A wrong-opcode strobe and a second strobe sent in the middle of an operation with different operands check that neither one disturbs the output.

// File: rtl/regpair_mul_pkg.sv
package regpair_mul_pkg;

  // Per-cycle commands from the sequencer to the arithmetic path
  typedef struct packed {
    logic load;    // capture operands and flags
    logic step;    // retire one multiplier bit
    logic commit;  // publish result pair and flags
  } ctrlStrobes_t;

endpackage

// File: rtl/regpair_mul_ctrl.sv
module regpair_mul_ctrl
  import regpair_mul_pkg::*;
#(
  parameter int OPW     = 8,
  parameter int W       = 8,
  parameter int LATENCY = 11,
  parameter int OPCODE  = 'h42
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           startValid,
  input  logic [OPW-1:0] startOpcode,
  output logic           busy,
  output logic           done,
  output ctrlStrobes_t   strobes
);

  localparam int CW        = $clog2(LATENCY + 1);
  localparam int LAST_STEP = LATENCY - 1 - W;

  logic [CW-1:0] cnt;
  logic          accept;

  initial begin
    if (LATENCY < W + 2) $error("LATENCY too short for W steps");
  end

  assign accept = startValid && (startOpcode == OPW'(OPCODE)) && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        cnt  <= CW'(LATENCY - 1);
      end else if (busy) begin
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
          cnt  <= '0;
        end else begin
          cnt <= cnt - CW'(1);
        end
      end
    end
  end

  always_comb begin
    strobes        = '0;
    strobes.load   = accept;
    strobes.step   = busy && (cnt > CW'(LAST_STEP));
    strobes.commit = busy && (cnt == CW'(1));
  end

endmodule

// File: rtl/regpair_mul_dp.sv
module regpair_mul_dp
  import regpair_mul_pkg::*;
#(
  parameter int W     = 8,
  parameter int CCRW  = 8,
  parameter int H_BIT = 4,
  parameter int C_BIT = 0
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobes_t    strobes,
  input  logic [W-1:0]    accIn,
  input  logic [W-1:0]    idxIn,
  input  logic [CCRW-1:0] ccrIn,
  output logic [W-1:0]    accOut,
  output logic [W-1:0]    idxOut,
  output logic [CCRW-1:0] ccrOut
);

  logic [W-1:0]    mcand;
  logic [W-1:0]    hiAcc;
  logic [W-1:0]    loMul;
  logic [CCRW-1:0] ccrHold;
  logic [CCRW-1:0] ccrNext;
  logic [W:0]      partSum;

  // Flag pass-through with the two carry-type bits forced low
  for (genvar b = 0; b < CCRW; b++) begin : g_ccr
    if (b == H_BIT || b == C_BIT) begin : g_clr
      assign ccrNext[b] = 1'b0;
    end else begin : g_keep
      assign ccrNext[b] = ccrHold[b];
    end
  end

  assign partSum = {1'b0, hiAcc} + (loMul[0] ? {1'b0, mcand} : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcand   <= '0;
      hiAcc   <= '0;
      loMul   <= '0;
      ccrHold <= '0;
    end else if (strobes.load) begin
      mcand   <= idxIn;
      hiAcc   <= '0;
      loMul   <= accIn;
      ccrHold <= ccrIn;
    end else if (strobes.step) begin
      hiAcc <= partSum[W:1];
      loMul <= {partSum[0], loMul[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accOut <= '0;
      idxOut <= '0;
      ccrOut <= '0;
    end else if (strobes.commit) begin
      accOut <= loMul;
      idxOut <= hiAcc;
      ccrOut <= ccrNext;
    end
  end

endmodule

// File: rtl/regpair_mul.sv
module regpair_mul
  import regpair_mul_pkg::*;
#(
  parameter int W       = 8,
  parameter int OPW     = 8,
  parameter int CCRW    = 8,
  parameter int LATENCY = 11,
  parameter int OPCODE  = 'h42,
  parameter int H_BIT   = 4,
  parameter int C_BIT   = 0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startValid,
  input  logic [OPW-1:0]  startOpcode,
  input  logic [W-1:0]    accIn,
  input  logic [W-1:0]    idxIn,
  input  logic [CCRW-1:0] ccrIn,
  output logic            busy,
  output logic            done,
  output logic [W-1:0]    accOut,
  output logic [W-1:0]    idxOut,
  output logic [CCRW-1:0] ccrOut
);

  ctrlStrobes_t strobes;

  regpair_mul_ctrl #(
    .OPW(OPW), .W(W), .LATENCY(LATENCY), .OPCODE(OPCODE)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .startValid(startValid), .startOpcode(startOpcode),
    .busy(busy), .done(done), .strobes(strobes)
  );

  regpair_mul_dp #(
    .W(W), .CCRW(CCRW), .H_BIT(H_BIT), .C_BIT(C_BIT)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .accIn(accIn), .idxIn(idxIn), .ccrIn(ccrIn),
    .accOut(accOut), .idxOut(idxOut), .ccrOut(ccrOut)
  );

endmodule

// File: rtl/regpair_mul_chk.sv
module regpair_mul_chk #(
  parameter int W       = 8,
  parameter int OPW     = 8,
  parameter int CCRW    = 8,
  parameter int LATENCY = 11,
  parameter int OPCODE  = 'h42,
  parameter int H_BIT   = 4,
  parameter int C_BIT   = 0
) (
  input logic            clk,
  input logic            rstN,
  input logic            startValid,
  input logic [OPW-1:0]  startOpcode,
  input logic [W-1:0]    accIn,
  input logic [W-1:0]    idxIn,
  input logic [CCRW-1:0] ccrIn,
  input logic            busy,
  input logic            done,
  input logic [W-1:0]    accOut,
  input logic [W-1:0]    idxOut,
  input logic [CCRW-1:0] ccrOut
);

  localparam int LW = $clog2(LATENCY + 2);
  localparam logic [CCRW-1:0] CLRMASK = CCRW'((1 << H_BIT) | (1 << C_BIT));

  logic            taken;
  logic            running;
  logic [LW-1:0]   latCnt;
  logic [2*W-1:0]  expProd;
  logic [CCRW-1:0] expCcr;

  assign taken = startValid && (startOpcode == OPW'(OPCODE)) && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      latCnt  <= '0;
      expProd <= '0;
      expCcr  <= '0;
    end else if (taken) begin
      running <= 1'b1;
      latCnt  <= LW'(1);
      expProd <= (2*W)'(idxIn) * (2*W)'(accIn);
      expCcr  <= ccrIn;
    end else if (running) begin
      latCnt <= latCnt + LW'(1);
      if (done) running <= 1'b0;
    end
  end

  assert_busy_done_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (running && latCnt == LW'(LATENCY)));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_product_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ({idxOut, accOut} == expProd));

  assert_flags_cleared_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!ccrOut[H_BIT] && !ccrOut[C_BIT]));

  assert_flags_kept_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ((ccrOut & ~CLRMASK) == (expCcr & ~CLRMASK)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable({idxOut, accOut, ccrOut}));

  assert_wrong_opcode_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startValid && startOpcode != OPW'(OPCODE)) |=> !busy);

endmodule

bind regpair_mul regpair_mul_chk #(
  .W(W), .OPW(OPW), .CCRW(CCRW), .LATENCY(LATENCY),
  .OPCODE(OPCODE), .H_BIT(H_BIT), .C_BIT(C_BIT)
) i_chk (
  .clk(clk), .rstN(rstN), .startValid(startValid), .startOpcode(startOpcode),
  .accIn(accIn), .idxIn(idxIn), .ccrIn(ccrIn), .busy(busy), .done(done),
  .accOut(accOut), .idxOut(idxOut), .ccrOut(ccrOut)
);

// File: tb/test_regpair_mul.sv
module test_regpair_mul;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startValid = 1'b0;
  logic [7:0] startOpcode = '0;
  logic [7:0] accIn = '0;
  logic [7:0] idxIn = '0;
  logic [7:0] ccrIn = '0;
  logic       busy, done;
  logic [7:0] accOut, idxOut, ccrOut;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  regpair_mul i_regpair_mul (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startOpcode(startOpcode),
    .accIn(accIn), .idxIn(idxIn), .ccrIn(ccrIn), .busy(busy), .done(done),
    .accOut(accOut), .idxOut(idxOut), .ccrOut(ccrOut)
  );

  function automatic logic [15:0] refMul(logic [7:0] x, logic [7:0] a);
    return 16'(x) * 16'(a);
  endfunction

  function automatic logic [7:0] refCcr(logic [7:0] c);
    return c & 8'hEE;  // bit 4 and bit 0 cleared
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // One operation; optional intruding strobe while busy (R8)
  task automatic runOp(logic [7:0] x, logic [7:0] a, logic [7:0] c, bit intrude);
    logic [15:0] prevPair;
    logic [7:0]  prevCcr;
    @(negedge clk);
    prevPair = {idxOut, accOut};
    prevCcr  = ccrOut;
    startValid = 1'b1; startOpcode = 8'h42; idxIn = x; accIn = a; ccrIn = c;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      startValid = 1'b0; idxIn = ~x; accIn = ~a; ccrIn = ~c;
      if (intrude && i == 4) begin
        startValid = 1'b1; startOpcode = 8'h42;
      end
      if (i == 1 || i == 10) begin
        check("R6 busy", {busy, done}, 2'b10);
        check("R7 hold", {idxOut, accOut, ccrOut}, {prevPair, prevCcr});
      end
    end
    @(negedge clk);
    startValid = 1'b0;
    check("R6 done", {busy, done}, 2'b01);
    check(intrude ? "R8 product" : "R2 product", {idxOut, accOut}, refMul(x, a));
    check("R4/R5 flags", ccrOut, refCcr(c));
    @(negedge clk);
    check("R6 pulse", done, 1'b0);
  endtask

  initial begin
    #(200000 * 8);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset", {busy, done, accOut, idxOut, ccrOut}, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 after release", {busy, done, accOut, idxOut, ccrOut}, '0);

    // R1: wrong opcode ignored
    startValid = 1'b1; startOpcode = 8'h43; idxIn = 8'h12; accIn = 8'h34; ccrIn = 8'hFF;
    @(negedge clk);
    startValid = 1'b0;
    check("R1 busy", busy, 1'b0);
    repeat (12) @(negedge clk);
    check("R1 no change", {done, accOut, idxOut, ccrOut}, '0);

    // R10 corners, R3 byte order
    runOp(8'hFF, 8'hFF, 8'hFF, 0);
    check("R10 ff*ff", {idxOut, accOut}, 16'hFE01);
    runOp(8'hFF, 8'h02, 8'h11, 0);
    check("R3 high", idxOut, 8'h01);
    check("R3 low", accOut, 8'hFE);
    runOp(8'h00, 8'hA5, 8'h0E, 0);
    check("R10 zero x", {idxOut, accOut}, 16'h0000);
    runOp(8'h5A, 8'h00, 8'h00, 0);
    check("R10 zero a", {idxOut, accOut}, 16'h0000);
    runOp(8'h01, 8'hC3, 8'hE1, 0);
    check("R10 one x", {idxOut, accOut}, 16'h00C3);
    runOp(8'h9B, 8'h01, 8'h1F, 0);
    check("R10 one a", {idxOut, accOut}, 16'h009B);

    // R8: strobe while busy
    runOp(8'h37, 8'h6D, 8'h0A, 1);

    // Random operands and flags
    for (int n = 0; n < 40; n++) begin
      runOp(8'($urandom), 8'($urandom), 8'($urandom), (n % 5) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule